// File: doc/BRIEF.md
# MII Management Read Controller

This block lets a host fetch a 16-bit PHY register over a two-wire serial management bus (clock `mdc`, bidirectional data split into `mdio_o`, `mdio_oe` and `mdio_i`). The host sees a small byte-wide register set selected by a 2-bit bank number and a 5-bit offset. It writes the PHY register number and then sets a command bit. While the serial frame runs, the host polls a busy flag. Once busy clears, it collects the result as two separate bytes.

Each frame is 64 bits long and runs on a management clock derived from the system clock by the `CLK_DIV` parameter. The first 46 bits are driven by the block: a run of 32 ones, the start pattern, the read opcode, the PHY address (parameter `PHY_ADDR`) and the register number. After that the block releases the line for the 2 turnaround bits and then takes in 16 data bits, most significant bit first.

Top module: `mii_mgmt_reader`

## Requirements
- R1: After reset, and after a reset applied in the middle of a frame, `mdc`, `mdio_oe` and `mdio_o` are low, and every host-visible register reads 0: address, command, status, result low and result high.
- R2: A host write to bank 2 offset 0x12 with bit 0 set, made while idle, starts a frame. The busy bit (bank 3 offset 0x0A, bit 0) reads 1 from the same clock edge that stores the write. The same write made to any other bank starts nothing.
- R3: `mdc` is low while idle. During a frame it has a period of `CLK_DIV` system clocks, its first rising edge comes `CLK_DIV/2` cycles after the starting edge, and it rises exactly 64 times.
- R4: Over the first 46 bits the block drives (`mdio_oe` high) the following, each field MSB first: 32 ones, then 0 1 1 0, then `PHY_ADDR`, then the 5-bit register number held at bank 2 offset 0x14 (bits 4:0) when the frame started. Each bit changes only on a falling edge of `mdc`.
- R5: For bits 46 to 63 (turnaround and data), `mdio_oe` is low and `mdio_o` is low.
- R6: `mdio_i` is sampled on the rising `mdc` edges of bits 48 to 63, MSB first. The 16-bit result reads with bits 15:8 at bank 2 offset 0x19 and bits 7:0 at bank 2 offset 0x18.
- R7: Busy falls on the falling `mdc` edge that ends bit 63, exactly 64*`CLK_DIV` cycles after the starting edge. The result registers update on that same edge and nowhere else.
- R8: A write to the command register while busy is ignored. The frame does not restart, the command bit read back is unchanged, and the frame length stays the same.
- R9: The address register reads back the last value written. Writing it during a frame does not change the frame in progress, but the next frame uses the new value.
- R10: The host clears the command bit by writing 0 when idle. The result stays readable and unchanged until the next frame ends. Offsets that are not defined read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host write strobe, one cycle per write |
| reg_bank | input | 2 | Host bank select |
| reg_off | input | 5 | Host register offset within the bank |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for the selected bank and offset (combinational) |
| mdc | output | 1 | Management clock toward the PHY |
| mdio_i | input | 1 | Management data from the PHY |
| mdio_o | output | 1 | Management data toward the PHY |
| mdio_oe | output | 1 | High while the block drives the data line |

## Verification
The assertions assume that the host issues at most one register write per cycle, holds `reg_we` for a single cycle, and keeps reset asserted across at least one clock edge. They also assume the PHY changes `mdio_i` only while `mdc` is high or idle. The bench drives writes one at a time from tasks that raise `reg_we` for exactly one cycle, and holds reset for several cycles. Its PHY model updates `mdio_i` only just after it sees a rising `mdc` and parks the line high outside the data window, so any sample taken in the turnaround would corrupt the result.

// File: rtl/mii_rd_pkg.sv
package mii_rd_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned BANK_W     = 2;
    localparam int unsigned OFF_W      = 5;
    localparam int unsigned ADDR_W     = 5;
    localparam int unsigned PRE_BITS   = 32;
    localparam int unsigned TA_BITS    = 2;
    localparam int unsigned DATA_BITS  = 16;
    localparam int unsigned HDR_BITS   = PRE_BITS + 4 + 2 * ADDR_W;
    localparam int unsigned FRAME_BITS = HDR_BITS + TA_BITS + DATA_BITS;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;

    localparam logic [BANK_W-1:0] BANK_MII  = 2'd2;
    localparam logic [BANK_W-1:0] BANK_STAT = 2'd3;
    localparam logic [OFF_W-1:0]  OFF_CMD   = 5'h12;
    localparam logic [OFF_W-1:0]  OFF_ADDR  = 5'h14;
    localparam logic [OFF_W-1:0]  OFF_RD_LO = 5'h18;
    localparam logic [OFF_W-1:0]  OFF_RD_HI = 5'h19;
    localparam logic [OFF_W-1:0]  OFF_STAT  = 5'h0A;

    function automatic logic [HDR_BITS-1:0] mk_header(input logic [ADDR_W-1:0] phy,
                                                      input logic [ADDR_W-1:0] ra);
        return {{PRE_BITS{1'b1}}, START_CODE, OP_READ, phy, ra};
    endfunction

endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t div_d, div_q;
    logic edge_now;

    always_comb begin
        div_d    = div_q;
        edge_now = run && (div_q.cnt == TOP);
        if (!run) begin
            div_d.cnt = '0;
            div_d.mdc = 1'b0;
        end else if (edge_now) begin
            div_d.cnt = '0;
            div_d.mdc = ~div_q.mdc;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc  = div_q.mdc;
    assign rise = edge_now && !div_q.mdc;
    assign fall = edge_now &&  div_q.mdc;
endmodule

// File: rtl/mii_rd_engine.sv
module mii_rd_engine
    import mii_rd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic [DATA_BITS-1:0] result
);
    localparam int unsigned BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT   = BW'(FRAME_BITS - 1);
    localparam logic [BW-1:0] DATA_FIRST = BW'(HDR_BITS + TA_BITS);
    localparam logic [BW-1:0] HDR_END    = BW'(HDR_BITS);

    typedef struct packed {
        logic                 busy;
        logic [BW-1:0]        bitn;
        logic [HDR_BITS-1:0]  hdr;
        logic [DATA_BITS-1:0] shift;
        logic [DATA_BITS-1:0] result;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        if (!eng_q.busy) begin
            if (start) begin
                eng_d.busy = 1'b1;
                eng_d.bitn = '0;
                eng_d.hdr  = mk_header(PHY_ADDR, reg_addr);
            end
        end else begin
            if (rise && (eng_q.bitn >= DATA_FIRST)) begin
                eng_d.shift = {eng_q.shift[DATA_BITS-2:0], mdio_i};
            end
            if (fall) begin
                if (eng_q.bitn == LAST_BIT) begin
                    eng_d.busy   = 1'b0;
                    eng_d.bitn   = '0;
                    eng_d.result = eng_q.shift;
                end else begin
                    eng_d.bitn = eng_q.bitn + 1'b1;
                    eng_d.hdr  = {eng_q.hdr[HDR_BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy    = eng_q.busy;
    assign mdio_oe = eng_q.busy && (eng_q.bitn < HDR_END);
    assign mdio_o  = mdio_oe && eng_q.hdr[HDR_BITS-1];
    assign result  = eng_q.result;
endmodule

// File: rtl/mii_mgmt_reader.sv
module mii_mgmt_reader
    import mii_rd_pkg::*;
#(
    parameter int unsigned       CLK_DIV  = 8,
    parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [BANK_W-1:0] reg_bank,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int unsigned HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              cmd;
    } host_t;

    host_t host_d, host_q;
    logic  busy, rise, fall, start, cmd_bit;
    logic  wr_cmd, wr_addr;
    logic [DATA_BITS-1:0] result;
    logic [BYTE_W-ADDR_W-1:0] unused_wdata_hi;

    assign unused_wdata_hi = reg_wdata[BYTE_W-1:ADDR_W];

    always_comb begin
        host_d  = host_q;
        wr_cmd  = reg_we && (reg_bank == BANK_MII) && (reg_off == OFF_CMD);
        wr_addr = reg_we && (reg_bank == BANK_MII) && (reg_off == OFF_ADDR);
        start   = wr_cmd && reg_wdata[0] && !busy;
        if (wr_cmd && !busy) host_d.cmd  = reg_wdata[0];
        if (wr_addr)         host_d.addr = reg_wdata[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_q <= '0;
        else        host_q <= host_d;
    end

    assign cmd_bit = host_q.cmd;

    always_comb begin
        reg_rdata = '0;
        if (reg_bank == BANK_MII) begin
            case (reg_off)
                OFF_ADDR:  reg_rdata = BYTE_W'(host_q.addr);
                OFF_CMD:   reg_rdata = BYTE_W'(host_q.cmd);
                OFF_RD_LO: reg_rdata = result[BYTE_W-1:0];
                OFF_RD_HI: reg_rdata = result[DATA_BITS-1:BYTE_W];
                default:   reg_rdata = '0;
            endcase
        end else if ((reg_bank == BANK_STAT) && (reg_off == OFF_STAT)) begin
            reg_rdata = BYTE_W'(busy);
        end
    end

    mii_mdc_gen #(.HALF(HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mii_rd_engine #(.PHY_ADDR(PHY_ADDR)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .reg_addr(host_q.addr),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .result  (result)
    );
endmodule

// File: rtl/mii_mgmt_reader_chk.sv
module mii_mgmt_reader_chk
    import mii_rd_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [BANK_W-1:0]    reg_bank,
    input logic [OFF_W-1:0]     reg_off,
    input logic                 wbit0,
    input logic                 mdc,
    input logic                 mdio_o,
    input logic                 mdio_oe,
    input logic                 busy,
    input logic                 cmd,
    input logic [DATA_BITS-1:0] result
);
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_bank == BANK_MII && reg_off == OFF_CMD && wbit0 && !busy) |=> busy); // R2

    AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe && !mdio_o)); // R3

    AST_MDO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$stable(mdio_o)) |-> $fell(mdc)); // R4

    AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$stable(mdio_oe)) |-> $fell(mdc)); // R5

    AST_RESULT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(busy)); // R7

    AST_END_ON_MDC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(mdc)); // R7

    AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(cmd)); // R8
endmodule

bind mii_mgmt_reader mii_mgmt_reader_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_we  (reg_we),
    .reg_bank(reg_bank),
    .reg_off (reg_off),
    .wbit0   (reg_wdata[0]),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (busy),
    .cmd     (cmd_bit),
    .result  (result)
);

// File: tb/mii_mgmt_reader_tb.sv
`timescale 1ns/1ps
module mii_mgmt_reader_tb;
    import mii_rd_pkg::*;

    localparam int DIV = 4;
    localparam int H = DIV / 2;
    localparam int FRAME_CYC = 64 * DIV;
    localparam logic [4:0] PHY = 5'h01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_bank = '0;
    logic [4:0] reg_off = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic mdc, mdio_o, mdio_oe;
    logic mdio_i = 1'b1;

    always #2.5 clk = ~clk;

    mii_mgmt_reader #(.CLK_DIV(DIV), .PHY_ADDR(PHY)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_bank(reg_bank),
        .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    int errs = 0;
    int checks = 0;
    int cyc_count = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] phy_val(input logic [4:0] a);
        if (a == 5'd2) return 16'h0083;
        if (a == 5'd3) return 16'h1405;
        return {3'b101, a, ~a, 3'b011};
    endfunction

    // behavioural reference: frame timeline counted in cycles
    bit m_busy = 0;
    int m_t = 0;
    logic [45:0] m_hdr = '0;
    logic [4:0] m_addr = '0;

    always @(posedge clk) begin
        cyc_count++;
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_addr = '0;
        end else begin
            if (!m_busy && reg_we && reg_bank == 2'd2 && reg_off == 5'h12 && reg_wdata[0]) begin
                m_busy = 1; m_t = 0;
                m_hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, PHY, m_addr};
            end else if (m_busy) begin
                m_t++;
                if (m_t == FRAME_CYC) m_busy = 0;
            end
            if (reg_we && reg_bank == 2'd2 && reg_off == 5'h14) m_addr = reg_wdata[4:0];
        end
        if (cyc_count > 150000 && !finished) begin
            errs++; checks++;
            $display("FAIL R7 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // per-clock comparison plus PHY model
    int idx;
    bit e_mdc, e_oe, e_o;
    int pc = 0;
    int last_rises = 0;
    bit prev_mdc = 0;
    logic [45:0] phy_hdr = '0;
    logic [15:0] pdata = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            idx   = m_t / (2 * H);
            e_mdc = m_busy && (((m_t / H) % 2) == 1);
            e_oe  = m_busy && (idx < 46);
            e_o   = e_oe ? m_hdr[45 - idx] : 1'b0;
            chk(mdc == e_mdc, "R3", "mdc", 32'(mdc), 32'(e_mdc));
            chk(mdio_oe == e_oe, e_oe ? "R4" : "R5", "mdio_oe", 32'(mdio_oe), 32'(e_oe));
            chk(mdio_o == e_o, e_oe ? "R4" : "R5", "mdio_o", 32'(mdio_o), 32'(e_o));
        end
        if (!m_busy) begin
            if (pc != 0) last_rises = pc;
            pc = 0;
            mdio_i = 1'b1;
        end else if (mdc && !prev_mdc) begin
            if (pc < 46) phy_hdr[45 - pc] = mdio_o;
            if (pc == 45) pdata = phy_val(phy_hdr[4:0]);
            if (pc >= 47 && pc <= 62) mdio_i = pdata[62 - pc];
            else mdio_i = 1'b1;
            pc++;
        end
        prev_mdc = mdc;
    end

    task automatic wr(input logic [1:0] b, input logic [4:0] o, input logic [7:0] v);
        @(negedge clk);
        reg_bank = b; reg_off = o; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] b, input logic [4:0] o, output logic [7:0] v);
        reg_bank = b; reg_off = o;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(input int t0, input string req);
        logic [7:0] s;
        do begin
            @(negedge clk);
            rd(2'd3, 5'h0A, s);
        end while (s[0] && (cyc_count - t0) < FRAME_CYC + 64);
        chk((cyc_count - t0) == FRAME_CYC, req, "frame cycles", 32'(cyc_count - t0), 32'(FRAME_CYC));
    endtask

    task automatic check_result(input logic [15:0] exp, input string req);
        logic [7:0] hi, lo;
        rd(2'd2, 5'h19, hi);
        rd(2'd2, 5'h18, lo);
        chk({hi, lo} == exp, req, "result", 32'({hi, lo}), 32'(exp));
    endtask

    // start a frame and confirm busy is visible at the storing edge
    task automatic start_frame(output int t0);
        logic [7:0] s;
        wr(2'd2, 5'h12, 8'h01);
        t0 = cyc_count;
        rd(2'd3, 5'h0A, s);
        chk(s == 8'h01, "R2", "busy at start edge", 32'(s), 32'h1);
    endtask

    initial begin
        logic [7:0] v;
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins after reset", 32'({mdc, mdio_oe}), 32'h0);
        rd(2'd2, 5'h14, v); chk(v == 8'h00, "R1", "addr", 32'(v), 32'h0);
        rd(2'd2, 5'h12, v); chk(v == 8'h00, "R1", "cmd", 32'(v), 32'h0);
        rd(2'd3, 5'h0A, v); chk(v == 8'h00, "R1", "status", 32'(v), 32'h0);
        check_result(16'h0000, "R1");

        // R2 bank decode: wrong bank starts nothing
        wr(2'd0, 5'h12, 8'h01);
        @(negedge clk);
        rd(2'd3, 5'h0A, v); chk(v == 8'h00, "R2", "no start from bank 0", 32'(v), 32'h0);

        // first ID register
        wr(2'd2, 5'h14, 8'h02);
        rd(2'd2, 5'h14, v); chk(v == 8'h02, "R9", "addr readback", 32'(v), 32'h2);
        start_frame(t0);
        wait_idle(t0, "R7");
        chk(last_rises == 64, "R3", "mdc rises", 32'(last_rises), 32'd64);
        check_result(16'h0083, "R6");
        wr(2'd2, 5'h12, 8'h00);
        rd(2'd2, 5'h12, v); chk(v == 8'h00, "R10", "cmd cleared", 32'(v), 32'h0);
        check_result(16'h0083, "R10");

        // second ID register, masked check
        wr(2'd2, 5'h14, 8'h03);
        start_frame(t0);
        wait_idle(t0, "R7");
        rd(2'd2, 5'h19, v);
        chk((v & 8'hFC) == 8'h14, "R6", "id2 masked high", 32'(v & 8'hFC), 32'h14);
        check_result(16'h1405, "R6");

        // writes during a frame
        wr(2'd2, 5'h14, 8'h1B);
        start_frame(t0);
        repeat (20) @(negedge clk);
        check_result(16'h1405, "R7");
        wr(2'd2, 5'h12, 8'h00);
        rd(2'd2, 5'h12, v); chk(v == 8'h01, "R8", "cmd ignored while busy", 32'(v), 32'h1);
        wr(2'd2, 5'h12, 8'h01);
        wr(2'd2, 5'h14, 8'h05);
        rd(2'd2, 5'h14, v); chk(v == 8'h05, "R9", "addr written mid-frame", 32'(v), 32'h5);
        wait_idle(t0, "R8");
        check_result(phy_val(5'h1B), "R9");

        // next frame picks up the new address
        start_frame(t0);
        wait_idle(t0, "R7");
        check_result(phy_val(5'h05), "R9");

        // undefined offsets
        rd(2'd2, 5'h00, v); chk(v == 8'h00, "R10", "bank2 off 0", 32'(v), 32'h0);
        rd(2'd3, 5'h12, v); chk(v == 8'h00, "R10", "bank3 off 0x12", 32'(v), 32'h0);
        rd(2'd0, 5'h18, v); chk(v == 8'h00, "R10", "bank0 off 0x18", 32'(v), 32'h0);

        // reset in the middle of a frame
        start_frame(t0);
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(mdc == 1'b0 && mdio_oe == 1'b0 && mdio_o == 1'b0, "R1", "pins after mid-frame reset",
            32'({mdc, mdio_oe, mdio_o}), 32'h0);
        rd(2'd3, 5'h0A, v); chk(v == 8'h00, "R1", "status after reset", 32'(v), 32'h0);
        rd(2'd2, 5'h12, v); chk(v == 8'h00, "R1", "cmd after reset", 32'(v), 32'h0);
        rd(2'd2, 5'h14, v); chk(v == 8'h00, "R1", "addr after reset", 32'(v), 32'h0);
        check_result(16'h0000, "R1");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule